// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which of four DMA channels a transfer sequencer serves next. Each channel has an asynchronous hardware request line, whose active level is chosen by a configuration input, and a software request bit that a host sets or clears. A per-channel mask blocks hardware requests but never blocks software requests. A halt input stops all new grants. The surviving requests are arbitrated either by fixed priority or by a rotating scheme in which the channel just served drops to the bottom.

A grant is latched only when the sequencer reports idle and no grant is outstanding. The grant stays stable until the sequencer signals completion. When completion arrives with a terminal-count flag, the software request of the granted channel is cleared. The block drives a grant-valid flag, the granted channel index and per-channel acknowledge lines whose active level is also configurable. It also exposes the synchronized request level of every channel for status reads, whatever the mask holds.

Top module: `dma_req_arbiter`

## Requirements
- R1: `req_status[i]` equals `hw_req_in[i]` as sampled two rising edges earlier, inverted when `cfg_req_active_low` is 1. The mask has no effect on it. A request becomes active at that same level.
- R2: A hardware request of channel i is ignored for arbitration while mask bit i is 1. Reset sets every mask bit to 1.
- R3: Software request bit i takes part in arbitration whatever mask bit i holds. Reset clears all software request bits. `soft_bit_we` writes `soft_bit_val` into the bit selected by `soft_bit_sel`.
- R4: With `cfg_rotate` at 0, the lowest-numbered active channel wins, so channel 0 is highest and channel 3 lowest.
- R5: With `cfg_rotate` at 1, the search starts at the channel after the last one released and wraps around. After reset the last-released channel counts as 3, so channel 0 is searched first.
- R6: While `cfg_halt` is 1, no new grant is taken. A grant already held is kept.
- R7: A grant is latched on a rising edge only when `seq_idle` is 1, no grant is held and some request is active. `svc_valid` and `svc_ch` then stay unchanged until an edge with `seq_done` at 1 clears `svc_valid`. A new grant can be taken one edge later at the earliest.
- R8: `ack_out[i]` is at its active level only for the granted channel while `svc_valid` is 1. The active level is high when `cfg_ack_active_high` is 1 and low otherwise. With no grant, all lines sit at the inactive level.
- R9: An edge with `seq_done` and `seq_tc` both at 1 while a grant is held clears the software request bit of the granted channel. A software write in the same cycle takes precedence.
- R10: `mask_load` writes all mask bits from `mask_load_val`. `mask_bit_we` writes `mask_bit_val` into the bit chosen by `mask_bit_sel`, and it overrides a whole-mask load to that bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_req_active_low | input | 1 | Hardware request lines are active low when 1 |
| cfg_ack_active_high | input | 1 | Acknowledge lines are active high when 1 |
| cfg_rotate | input | 1 | 1 selects rotating priority, 0 selects fixed priority |
| cfg_halt | input | 1 | Blocks new grants when 1 |
| hw_req_in | input | 4 | Asynchronous hardware request lines |
| mask_load | input | 1 | Load the whole mask |
| mask_load_val | input | 4 | Mask value for a whole load |
| mask_bit_we | input | 1 | Write a single mask bit |
| mask_bit_sel | input | 2 | Channel of the single mask bit |
| mask_bit_val | input | 1 | Value of the single mask bit |
| soft_bit_we | input | 1 | Write a single software request bit |
| soft_bit_sel | input | 2 | Channel of the software request bit |
| soft_bit_val | input | 1 | Value of the software request bit |
| seq_idle | input | 1 | Sequencer is ready to accept a grant |
| seq_done | input | 1 | Sequencer has finished the current service |
| seq_tc | input | 1 | The finished service reached terminal count |
| svc_valid | output | 1 | A grant is held |
| svc_ch | output | 2 | Granted channel index |
| ack_out | output | 4 | Per-channel acknowledge lines in the configured level |
| req_status | output | 4 | Synchronized request level per channel, mask ignored |

## Verification
The arbiter is driven with a single masked request and then unmasked. It sees two competing hardware requests under fixed priority, and a masked hardware request alongside a software request. All four lines are driven with rotation on, followed by a sparse pattern that forces the rotation pointer to wrap. Fixed versus rotating order shows up only when a channel is re-served while others wait. The halt and sequencer-busy phases show whether the grant gate honours both conditions. The active-low request pattern and the same-cycle mask load with a bit override tell the polarity and write-precedence paths apart from the plain request path.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;

    localparam int CH_COUNT = 4;

    typedef enum logic {
        PRI_FIXED  = 1'b0,
        PRI_ROTATE = 1'b1
    } prio_mode_e;

    typedef struct packed {
        logic       req_low;
        logic       ack_high;
        prio_mode_e mode;
        logic       halt;
    } arb_cfg_t;

    // Modular add for small channel indices (base < n, off < n).
    function automatic int unsigned wrap_add(int unsigned base, int unsigned off, int unsigned n);
        int unsigned s;
        s = base + off;
        return (s >= n) ? (s - n) : s;
    endfunction

endpackage

// File: rtl/dmarb_sync.sv
module dmarb_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage_a;
    logic [W-1:0] stage_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_a <= '0;
            stage_b <= '0;
        end else begin
            stage_a <= async_in;
            stage_b <= stage_a;
        end
    end

    assign sync_out = stage_b;

endmodule

// File: rtl/dmarb_regs.sv
module dmarb_regs #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_load,
    input  logic [NUM_CH-1:0] mask_load_val,
    input  logic              mask_bit_we,
    input  logic [CH_W-1:0]   mask_bit_sel,
    input  logic              mask_bit_val,
    input  logic              soft_bit_we,
    input  logic [CH_W-1:0]   soft_bit_sel,
    input  logic              soft_bit_val,
    input  logic              soft_clr_en,
    input  logic [CH_W-1:0]   soft_clr_sel,
    output logic [NUM_CH-1:0] mask_q,
    output logic [NUM_CH-1:0] soft_q
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic mbit;
        logic sbit;
        logic mask_hit;
        logic soft_hit;
        logic clr_hit;

        assign mask_hit = mask_bit_we && (mask_bit_sel == CH_W'(i));
        assign soft_hit = soft_bit_we && (soft_bit_sel == CH_W'(i));
        assign clr_hit  = soft_clr_en && (soft_clr_sel == CH_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                mbit <= 1'b1;
            end else if (mask_hit) begin
                mbit <= mask_bit_val;
            end else if (mask_load) begin
                mbit <= mask_load_val[i];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                sbit <= 1'b0;
            end else if (soft_hit) begin
                sbit <= soft_bit_val;
            end else if (clr_hit) begin
                sbit <= 1'b0;
            end
        end

        assign mask_q[i] = mbit;
        assign soft_q[i] = sbit;
    end

endmodule

// File: rtl/dmarb_pick.sv
module dmarb_pick
    import dmarb_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic [NUM_CH-1:0] active,
    input  prio_mode_e        mode,
    input  logic [CH_W-1:0]   last_ch,
    output logic              win_valid,
    output logic [CH_W-1:0]   win_ch
);

    int unsigned start_pos;

    always_comb begin
        if (mode == PRI_ROTATE) begin
            start_pos = wrap_add(int'(last_ch), 1, NUM_CH);
        end else begin
            start_pos = 0;
        end
    end

    always_comb begin
        win_valid = 1'b0;
        win_ch    = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            int unsigned pos;
            pos = wrap_add(start_pos, k, NUM_CH);
            if (!win_valid && active[pos]) begin
                win_valid = 1'b1;
                win_ch    = CH_W'(pos);
            end
        end
    end

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dmarb_pkg::*;
#(
    parameter int NUM_CH = dmarb_pkg::CH_COUNT,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_req_active_low,
    input  logic              cfg_ack_active_high,
    input  logic              cfg_rotate,
    input  logic              cfg_halt,
    input  logic [NUM_CH-1:0] hw_req_in,
    input  logic              mask_load,
    input  logic [NUM_CH-1:0] mask_load_val,
    input  logic              mask_bit_we,
    input  logic [CH_W-1:0]   mask_bit_sel,
    input  logic              mask_bit_val,
    input  logic              soft_bit_we,
    input  logic [CH_W-1:0]   soft_bit_sel,
    input  logic              soft_bit_val,
    input  logic              seq_idle,
    input  logic              seq_done,
    input  logic              seq_tc,
    output logic              svc_valid,
    output logic [CH_W-1:0]   svc_ch,
    output logic [NUM_CH-1:0] ack_out,
    output logic [NUM_CH-1:0] req_status
);

    typedef struct packed {
        logic            live;
        logic [CH_W-1:0] ch;
    } grant_t;

    arb_cfg_t          cfg;
    logic [NUM_CH-1:0] req_sync;
    logic [NUM_CH-1:0] req_level;
    logic [NUM_CH-1:0] mask_q;
    logic [NUM_CH-1:0] soft_q;
    logic [NUM_CH-1:0] contend;
    logic              win_valid;
    logic [CH_W-1:0]   win_ch;
    logic [CH_W-1:0]   last_q;
    grant_t            gnt_q;
    logic              release_now;

    assign cfg.req_low  = cfg_req_active_low;
    assign cfg.ack_high = cfg_ack_active_high;
    assign cfg.mode     = cfg_rotate ? PRI_ROTATE : PRI_FIXED;
    assign cfg.halt     = cfg_halt;

    dmarb_sync #(.W(NUM_CH)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (hw_req_in),
        .sync_out (req_sync)
    );

    assign req_level  = req_sync ^ {NUM_CH{cfg.req_low}};
    assign req_status = req_level;

    assign release_now = gnt_q.live && seq_done;

    dmarb_regs #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_regs (
        .clk           (clk),
        .rst           (rst),
        .mask_load     (mask_load),
        .mask_load_val (mask_load_val),
        .mask_bit_we   (mask_bit_we),
        .mask_bit_sel  (mask_bit_sel),
        .mask_bit_val  (mask_bit_val),
        .soft_bit_we   (soft_bit_we),
        .soft_bit_sel  (soft_bit_sel),
        .soft_bit_val  (soft_bit_val),
        .soft_clr_en   (release_now && seq_tc),
        .soft_clr_sel  (gnt_q.ch),
        .mask_q        (mask_q),
        .soft_q        (soft_q)
    );

    always_comb begin
        if (cfg.halt) begin
            contend = '0;
        end else begin
            contend = (req_level & ~mask_q) | soft_q;
        end
    end

    dmarb_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
        .active    (contend),
        .mode      (cfg.mode),
        .last_ch   (last_q),
        .win_valid (win_valid),
        .win_ch    (win_ch)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_q  <= '0;
            last_q <= CH_W'(NUM_CH - 1);
        end else if (gnt_q.live) begin
            if (seq_done) begin
                gnt_q.live <= 1'b0;
                last_q     <= gnt_q.ch;
            end
        end else if (seq_idle && win_valid) begin
            gnt_q.live <= 1'b1;
            gnt_q.ch   <= win_ch;
        end
    end

    assign svc_valid = gnt_q.live;
    assign svc_ch    = gnt_q.ch;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ack
        logic picked;
        assign picked     = gnt_q.live && (gnt_q.ch == CH_W'(i));
        assign ack_out[i] = picked ^ ~cfg.ack_high;
    end

endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_req_active_low,
    input logic              cfg_ack_active_high,
    input logic              cfg_halt,
    input logic [NUM_CH-1:0] hw_req_in,
    input logic              seq_idle,
    input logic              seq_done,
    input logic              svc_valid,
    input logic [CH_W-1:0]   svc_ch,
    input logic [NUM_CH-1:0] ack_out,
    input logic [NUM_CH-1:0] req_status
);

    logic [1:0] warm;

    always_ff @(posedge clk) begin
        if (rst) begin
            warm <= '0;
        end else if (warm != 2'd3) begin
            warm <= warm + 2'd1;
        end
    end

    assert_sync_R1: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2) |-> (req_status == ($past(hw_req_in, 2) ^ {NUM_CH{cfg_req_active_low}})));

    assert_halt_R6: assert property (@(posedge clk) disable iff (rst)
        (!svc_valid && cfg_halt) |=> !svc_valid);

    assert_wait_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (!svc_valid && !seq_idle) |=> !svc_valid);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (svc_valid && !seq_done) |=> (svc_valid && $stable(svc_ch)));

    assert_ack_one_R8: assert property (@(posedge clk) disable iff (rst)
        svc_valid |-> ($countones(ack_out ^ {NUM_CH{!cfg_ack_active_high}}) == 1));

    assert_ack_match_R8: assert property (@(posedge clk) disable iff (rst)
        svc_valid |-> (ack_out[svc_ch] == cfg_ack_active_high));

    assert_ack_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !svc_valid |-> (ack_out == {NUM_CH{!cfg_ack_active_high}}));

endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
    .clk                 (clk),
    .rst                 (rst),
    .cfg_req_active_low  (cfg_req_active_low),
    .cfg_ack_active_high (cfg_ack_active_high),
    .cfg_halt            (cfg_halt),
    .hw_req_in           (hw_req_in),
    .seq_idle            (seq_idle),
    .seq_done            (seq_done),
    .svc_valid           (svc_valid),
    .svc_ch              (svc_ch),
    .ack_out             (ack_out),
    .req_status          (req_status)
);

// File: tb/tb_dma_req_arbiter.sv
module tb_dma_req_arbiter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_low = 1'b0, cfg_ackh = 1'b0, cfg_rot = 1'b0, cfg_halt = 1'b0;
    logic [3:0] hw = 4'b0;
    logic       mask_load = 1'b0;
    logic [3:0] mask_load_val = 4'b0;
    logic       mask_bit_we = 1'b0;
    logic [1:0] mask_bit_sel = 2'd0;
    logic       mask_bit_val = 1'b0;
    logic       soft_we = 1'b0;
    logic [1:0] soft_sel = 2'd0;
    logic       soft_val = 1'b0;
    logic       seq_idle = 1'b0, seq_done = 1'b0, seq_tc = 1'b0;
    logic       svc_valid;
    logic [1:0] svc_ch;
    logic [3:0] ack_out;
    logic [3:0] req_status;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit cmp_on = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dma_req_arbiter dut (
        .clk(clk), .rst(rst),
        .cfg_req_active_low(cfg_low), .cfg_ack_active_high(cfg_ackh),
        .cfg_rotate(cfg_rot), .cfg_halt(cfg_halt),
        .hw_req_in(hw),
        .mask_load(mask_load), .mask_load_val(mask_load_val),
        .mask_bit_we(mask_bit_we), .mask_bit_sel(mask_bit_sel), .mask_bit_val(mask_bit_val),
        .soft_bit_we(soft_we), .soft_bit_sel(soft_sel), .soft_bit_val(soft_val),
        .seq_idle(seq_idle), .seq_done(seq_done), .seq_tc(seq_tc),
        .svc_valid(svc_valid), .svc_ch(svc_ch), .ack_out(ack_out), .req_status(req_status)
    );

    // Behavioural reference state
    logic [3:0] m_s1, m_s2, m_mask, m_soft;
    logic       m_gv;
    int         m_gch, m_last;

    always @(posedge clk) begin : model
        logic [3:0] lvl;
        logic [3:0] eff;
        int win;
        bit found;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_mask = 4'hF; m_soft = 0;
            m_gv = 0; m_gch = 0; m_last = 3;
        end else begin
            lvl = m_s2 ^ {4{cfg_low}};
            eff = cfg_halt ? 4'b0 : ((lvl & ~m_mask) | m_soft);
            found = 0; win = 0;
            for (int k = 0; k < 4; k++) begin
                int c;
                c = cfg_rot ? ((m_last + 1 + k) % 4) : k;
                if (!found && eff[c]) begin found = 1; win = c; end
            end
            if (m_gv) begin
                if (seq_done) begin
                    m_gv = 0; m_last = m_gch;
                    if (seq_tc) m_soft[m_gch] = 1'b0;
                end
            end else if (seq_idle && found) begin
                m_gv = 1; m_gch = win;
            end
            if (soft_we) m_soft[soft_sel] = soft_val;
            if (mask_load) m_mask = mask_load_val;
            if (mask_bit_we) m_mask[mask_bit_sel] = mask_bit_val;
            m_s2 = m_s1; m_s1 = hw;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            logic [3:0] oh;
            oh = m_gv ? (4'b1 << m_gch) : 4'b0;
            chk("R1 status", {28'b0, req_status}, {28'b0, m_s2 ^ {4{cfg_low}}});
            chk("R7 svc_valid", {31'b0, svc_valid}, {31'b0, m_gv});
            if (m_gv) chk("R4 R5 svc_ch", {30'b0, svc_ch}, m_gch);
            chk("R8 ack", {28'b0, ack_out}, {28'b0, cfg_ackh ? oh : ~oh});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic look;
        @(negedge clk); #1;
    endtask

    task automatic done_pulse(logic tc);
        seq_done = 1; seq_tc = tc; step(1); seq_done = 0; seq_tc = 0;
    endtask

    initial begin
        step(3);
        rst = 0;
        cmp_on = 1;
        look;
        chk("R7 reset valid", {31'b0, svc_valid}, 0);
        chk("R8 reset ack", {28'b0, ack_out}, 4'hF);
        chk("R1 reset status", {28'b0, req_status}, 0);

        // Masked request after reset
        step(1);
        seq_idle = 1; hw = 4'b0100; step(5); look;
        chk("R2 masked not granted", {31'b0, svc_valid}, 0);
        chk("R1 status ignores mask", {28'b0, req_status}, 4'b0100);

        // Unmask
        step(1);
        mask_load = 1; mask_load_val = 4'b0; step(1); mask_load = 0;
        step(3); look;
        chk("R2 unmasked grant valid", {31'b0, svc_valid}, 1);
        chk("R2 unmasked grant ch", {30'b0, svc_ch}, 2);
        chk("R8 ack low level", {28'b0, ack_out}, 4'b1011);
        step(1);
        seq_idle = 0; hw = 0; step(3); done_pulse(0); step(2);

        // Fixed priority
        hw = 4'b0110; step(4); seq_idle = 1; step(3); look;
        chk("R4 fixed first", {30'b0, svc_ch}, 1);
        step(1); done_pulse(0); step(3); look;
        chk("R4 fixed repeat", {30'b0, svc_ch}, 1);
        step(1); seq_idle = 0; hw = 0; step(3); done_pulse(0); step(2);

        // Software request bypasses mask, cleared at terminal count
        mask_load = 1; mask_load_val = 4'hF; step(1); mask_load = 0;
        hw = 4'b1000; soft_we = 1; soft_sel = 2'd3; soft_val = 1; step(1); soft_we = 0;
        step(4); seq_idle = 1; step(3); look;
        chk("R3 soft grant valid", {31'b0, svc_valid}, 1);
        chk("R3 soft grant ch", {30'b0, svc_ch}, 3);
        step(1); done_pulse(1); step(3); look;
        chk("R9 soft cleared", {31'b0, svc_valid}, 0);

        // Rotating priority
        step(1); seq_idle = 0; cfg_rot = 1; hw = 4'hF;
        mask_load = 1; mask_load_val = 4'b0; step(1); mask_load = 0;
        step(4); seq_idle = 1; step(3); look;
        chk("R5 rotate after 3", {30'b0, svc_ch}, 0);
        step(1); done_pulse(0); step(3); look;
        chk("R5 rotate after 0", {30'b0, svc_ch}, 1);
        step(1); done_pulse(0); step(3); look;
        chk("R5 rotate after 1", {30'b0, svc_ch}, 2);
        step(1); done_pulse(0); step(3); look;
        chk("R5 rotate after 2", {30'b0, svc_ch}, 3);
        step(1); hw = 4'b0101; step(3); done_pulse(0); step(3); look;
        chk("R5 wrap to 0", {30'b0, svc_ch}, 0);
        step(1); done_pulse(0); step(3); look;
        chk("R5 skip idle 1", {30'b0, svc_ch}, 2);

        // Halt
        step(1); cfg_halt = 1; done_pulse(0); step(4); look;
        chk("R6 halted", {31'b0, svc_valid}, 0);
        step(1); cfg_halt = 0; step(3); look;
        chk("R6 resumed valid", {31'b0, svc_valid}, 1);
        chk("R6 resumed ch", {30'b0, svc_ch}, 0);

        // Active-low requests, sequencer busy gate
        step(1); seq_idle = 0; done_pulse(0);
        cfg_low = 1; hw = 4'b1110; step(5); look;
        chk("R7 busy blocks grant", {31'b0, svc_valid}, 0);
        chk("R1 active low status", {28'b0, req_status}, 4'b0001);
        step(1); seq_idle = 1; step(3); look;
        chk("R1 active low grant", {30'b0, svc_ch}, 0);
        chk("R8 ack active low", {28'b0, ack_out}, 4'b1110);
        step(1); cfg_ackh = 1; look;
        chk("R8 ack active high", {28'b0, ack_out}, 4'b0001);

        // Whole-mask load with single-bit override
        step(1); seq_idle = 0; done_pulse(0);
        mask_load = 1; mask_load_val = 4'hF; mask_bit_we = 1; mask_bit_sel = 2'd1; mask_bit_val = 0;
        step(1); mask_load = 0; mask_bit_we = 0;
        hw = 4'b0101; step(4); seq_idle = 1; step(3); look;
        chk("R10 override valid", {31'b0, svc_valid}, 1);
        chk("R10 override ch", {30'b0, svc_ch}, 1);

        step(1); seq_idle = 0; done_pulse(0); step(3); look;
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule